// File: doc/BRIEF.md
# Timer-Overflow Divided Clock Output on a Port Pin

This block turns a 16-bit reloadable up-counter into a square-wave source and places that wave on one general-purpose port pin. The counter advances once for each timer tick while the timer is switched on. When it would step past its all-ones value, it takes the preload value instead and raises an overflow pulse for that cycle. Each overflow inverts a divide-by-two flip-flop. The wave on the pin therefore has the frequency f_tick / (2 x (65536 - N)), where N is the preload value.

The pin keeps its ordinary port behaviour. A direction bit selects input or output, and a port data latch bit holds the output value. When the divided-clock option is enabled and the pin is an output, the latch bit acts as a gate: 1 passes the divided wave and 0 holds the pin low. When the option is disabled, the pin drives the latch bit. In input mode the pad value is read back whatever the option setting.

Top module: `ptmr_freq_out`

## Requirements
- R1: After reset the counter, the preload register and the divide flip-flop are all 0, and `tmr_ovf` is 0.
- R2: The counter increments by one in each cycle where `tmr_run` and `tick_en` are both 1. In any other cycle it holds its value.
- R3: `tmr_ovf` is 1 exactly in a counting cycle where the counter holds 16'hFFFF. On the next edge the counter takes the preload value.
- R4: Each overflow inverts the divide flip-flop. With N preloaded and a tick in every cycle, the divided wave changes level every 65536 - N cycles.
- R5: While `tmr_run` is 0 the divide flip-flop keeps its value.
- R6: With `div_sel`=1, `pin_dir_out`=1 and `port_bit`=1, `pin_out` equals the divide flip-flop.
- R7: With `div_sel`=1 and `port_bit`=0, `pin_out` is 0.
- R8: With `div_sel`=0, `pin_out` equals `port_bit`.
- R9: With `pin_dir_out`=0, `pin_oe` is 0 and `rd_val` equals `pad_in`, whatever the value of `div_sel`.
- R10: With `pin_dir_out`=1, `pin_oe` is 1 and `rd_val` equals `port_bit`.
- R11: A preload write in the same cycle as an overflow takes effect at once: the counter reloads the newly written value.
- R12: A preload write while `tmr_run` is 0 also loads the written value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_run | input | 1 | Timer on |
| tick_en | input | 1 | Timer input tick, one cycle wide |
| pre_wr | input | 1 | Preload write strobe |
| pre_val | input | 16 | Preload value to write |
| div_sel | input | 1 | Divided-clock option enable for the pin |
| pin_dir_out | input | 1 | 1 = output mode, 0 = input mode |
| port_bit | input | 1 | Port data latch bit |
| pad_in | input | 1 | Pad input value |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad output enable |
| rd_val | output | 1 | Value the port returns on a read |
| tmr_ovf | output | 1 | Overflow pulse |

## Verification
The counter's reload at overflow and a software preload write can occur in the same cycle, and the write must win. The bench forces this case by waiting until `tmr_ovf` is seen high and then driving `pre_wr` with a new value in that same cycle. It judges the result by the number of cycles until the next overflow pulse, compared against a model that reloads with the newly written value. Random phases also mix writes with overflows and change pin modes at the same time as toggles, and every output is compared with the model on every cycle.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    // Source selected for the value driven onto the pad.
    typedef enum logic [1:0] {
        SRC_LATCH = 2'd0,
        SRC_DIV   = 2'd1,
        SRC_LOW   = 2'd2
    } pin_src_e;
endpackage

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] pre,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pre;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = run & tick;
        ovf  = step && (st_q.cnt == CNT_MAX);
        if (wr) begin
            st_d.pre = wr_val;
        end
        if (!run && wr) begin
            st_d.cnt = wr_val;
        end else if (step) begin
            // the reload uses the next preload, so a write in this cycle wins
            st_d.cnt = ovf ? st_d.pre : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign pre = st_q.pre;
endmodule

// File: rtl/ptmr_toggle.sv
module ptmr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    output logic div
);
    typedef struct packed {
        logic div;
    } tog_state_t;

    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovf) begin
            st_d.div = ~st_q.div;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div = st_q.div;
endmodule

// File: rtl/ptmr_pinmux.sv
module ptmr_pinmux
    import ptmr_pkg::*;
(
    input  logic div,
    input  logic div_sel,
    input  logic dir_out,
    input  logic latch,
    input  logic pad,
    output logic pin_out,
    output logic pin_oe,
    output logic rd_val
);
    pin_src_e src;

    always_comb begin
        if (!div_sel) begin
            src = SRC_LATCH;
        end else if (latch) begin
            src = SRC_DIV;
        end else begin
            src = SRC_LOW;
        end
        unique case (src)
            SRC_DIV: pin_out = div;
            SRC_LOW: pin_out = 1'b0;
            default: pin_out = latch;
        endcase
        pin_oe = dir_out;
        rd_val = dir_out ? latch : pad;
    end
endmodule

// File: rtl/ptmr_freq_out.sv
module ptmr_freq_out #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_run,
    input  logic             tick_en,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] pre_val,
    input  logic             div_sel,
    input  logic             pin_dir_out,
    input  logic             port_bit,
    input  logic             pad_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             rd_val,
    output logic             tmr_ovf
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pre_q;
    logic             div_q;

    ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .tick   (tick_en),
        .wr     (pre_wr),
        .wr_val (pre_val),
        .cnt    (cnt_q),
        .pre    (pre_q),
        .ovf    (tmr_ovf)
    );

    ptmr_toggle u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (tmr_ovf),
        .div   (div_q)
    );

    ptmr_pinmux u_mux (
        .div     (div_q),
        .div_sel (div_sel),
        .dir_out (pin_dir_out),
        .latch   (port_bit),
        .pad     (pad_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .rd_val  (rd_val)
    );
endmodule

// File: rtl/ptmr_freq_out_chk.sv
module ptmr_freq_out_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_run,
    input logic             tick_en,
    input logic             pre_wr,
    input logic             div_sel,
    input logic             pin_dir_out,
    input logic             port_bit,
    input logic             pad_in,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             rd_val,
    input logic             tmr_ovf,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] pre_q,
    input logic             div_q
);
    p_ovf_at_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> (cnt_q == {CNT_W{1'b1}}) && tmr_run && tick_en);

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && !pre_wr) |=> cnt_q == $past(pre_q));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && !tick_en) |=> $stable(cnt_q));

    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> div_q != $past(div_q));

    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_run |=> $stable(div_q));

    p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel && !port_bit) |-> !pin_out);

    p_plain_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !div_sel |-> pin_out == port_bit);

    p_input_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_dir_out |-> !pin_oe && (rd_val == pad_in));
endmodule

bind ptmr_freq_out ptmr_freq_out_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_run     (tmr_run),
    .tick_en     (tick_en),
    .pre_wr      (pre_wr),
    .div_sel     (div_sel),
    .pin_dir_out (pin_dir_out),
    .port_bit    (port_bit),
    .pad_in      (pad_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .rd_val      (rd_val),
    .tmr_ovf     (tmr_ovf),
    .cnt_q       (cnt_q),
    .pre_q       (pre_q),
    .div_q       (div_q)
);

// File: tb/ptmr_freq_out_tb.sv
module ptmr_freq_out_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tmr_run = 1'b0, tick_en = 1'b0, pre_wr = 1'b0;
    logic [W-1:0] pre_val = '0;
    logic div_sel = 1'b0, pin_dir_out = 1'b0, port_bit = 1'b0, pad_in = 1'b0;
    logic pin_out, pin_oe, rd_val, tmr_ovf;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference state
    logic [W-1:0] m_cnt = '0, m_pre = '0;
    logic m_tog = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptmr_freq_out u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_run(tmr_run), .tick_en(tick_en),
        .pre_wr(pre_wr), .pre_val(pre_val), .div_sel(div_sel),
        .pin_dir_out(pin_dir_out), .port_bit(port_bit), .pad_in(pad_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .rd_val(rd_val), .tmr_ovf(tmr_ovf)
    );

    function automatic logic exp_ovf(logic run, logic tk, logic [W-1:0] c);
        return run && tk && (c == '1);
    endfunction

    function automatic logic exp_pin(logic sel, logic pb, logic tg);
        if (!sel) return pb;
        return pb & tg;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_pre <= '0; m_tog <= 1'b0;
        end else begin
            logic [W-1:0] np;
            np = pre_wr ? pre_val : m_pre;
            m_pre <= np;
            if (!tmr_run && pre_wr) m_cnt <= pre_val;
            else if (tmr_run && tick_en) m_cnt <= (m_cnt == '1) ? np : m_cnt + 1'b1;
            if (exp_ovf(tmr_run, tick_en, m_cnt)) m_tog <= ~m_tog;
        end
    end

    task automatic check(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R3 ovf", tmr_ovf, exp_ovf(tmr_run, tick_en, m_cnt));
        if (!div_sel) check("R8 plain pin", pin_out, port_bit);
        else if (!port_bit) check("R7 gated low", pin_out, 1'b0);
        else check("R6 divided pin", pin_out, exp_pin(div_sel, port_bit, m_tog));
        if (pin_dir_out) begin
            check("R10 oe", pin_oe, 1'b1);
            check("R10 readback", rd_val, port_bit);
        end else begin
            check("R9 oe", pin_oe, 1'b0);
            check("R9 pad read", rd_val, pad_in);
        end
    endtask

    // one cycle: check at the falling edge, then move the inputs
    task automatic cyc();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the pins
        @(negedge clk);
        div_sel = 1'b1; port_bit = 1'b1; pin_dir_out = 1'b1;
        #1 check("R1 div flop zero", pin_out, 1'b0);
        check("R1 no ovf", tmr_ovf, 1'b0);

        // R12: load 16'hFFF0 with timer off, then run; R4 period 16
        pre_wr = 1'b1; pre_val = 16'hFFF0;
        cyc(); pre_wr = 1'b0; tmr_run = 1'b1; tick_en = 1'b1;
        begin
            int n = 0;
            logic last;
            last = pin_out;
            while (pin_out == last) begin cyc(); n++; end
            check("R12 first toggle after 16", n == 16, 1'b1);
            last = pin_out; n = 0;
            while (pin_out == last) begin cyc(); n++; end
            check("R4 half period 16", n == 16, 1'b1);
        end

        // R2: ticks gated off hold the count; no ovf appears
        tick_en = 1'b0;
        repeat (40) begin cyc(); check("R2 no count", tmr_ovf, 1'b0); end
        tick_en = 1'b1;

        // R5: timer off holds the flop
        tmr_run = 1'b0;
        begin
            logic held;
            cyc(); held = pin_out;
            repeat (40) begin cyc(); check("R5 hold", pin_out, held); end
        end
        tmr_run = 1'b1;

        // R11: write 16'hFFFA in the overflow cycle; next ovf 6 cycles later
        pre_wr = 1'b0;
        while (tmr_ovf !== 1'b1) cyc();
        pre_wr = 1'b1; pre_val = 16'hFFFA;
        begin
            int n = 0;
            cyc(); pre_wr = 1'b0;
            while (tmr_ovf !== 1'b1 && n < 100) begin cyc(); n++; end
            check("R11 reload takes new value", n == 5, 1'b1);
        end

        // R9: input mode ignores the option
        pin_dir_out = 1'b0;
        for (int i = 0; i < 4; i++) begin
            div_sel = i[0]; pad_in = i[1];
            cyc();
        end

        // random mixing
        for (int i = 0; i < 6000; i++) begin
            tmr_run     = ($urandom % 16) != 0;
            tick_en     = ($urandom % 4) != 0;
            pre_wr      = ($urandom % 50) == 0;
            pre_val     = 16'hFF00 | 16'($urandom % 256);
            div_sel     = ($urandom % 4) != 0;
            pin_dir_out = ($urandom % 3) != 0;
            port_bit    = ($urandom % 4) != 0;
            pad_in      = $urandom % 2;
            cyc();
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule